// File: doc/BRIEF.md
# SPI to parallel NAND command bridge

This block is a serial slave that lets a host reach an 8-bit parallel NAND flash over a four-wire serial link. The host lowers chip select, sends one opcode byte and then either a configuration byte or a stream of data byte slots. The configuration register drives the NAND chip enable, the command and address latch strobes, a fan output and four active-low LED outputs. Data bytes are either written to the NAND bus with a write-enable pulse each, or read from it with a read-enable pulse each and returned on the serial data-out line.

All serial inputs are brought into the system clock domain through synchronisers and their edges are found by oversampling. The serial clock must therefore run well below the system clock. Write data uses two input lanes, so a byte takes four serial clocks. Commands, configuration bytes and read slots use one lane, so a byte takes eight.

Top module: `spi_nand_bridge`

## Requirements
- R1: After reset the configuration register holds 0x8F: nand_ce_n=1, nand_cle=0, nand_ale=0, fan_on=0 and led_n=4'hF. The write and read strobes are high and nand_dq_oe is 0.
- R2: Opcode 0x09 loads the configuration register from each complete byte that follows it. Bit 7 drives nand_ce_n, bit 6 nand_cle, bit 5 nand_ale, bit 4 fan_on, and bits 3..0 drive led_n[3:0].
- R3: Opcode 0x08 (multi-write) takes each following byte two bits per rising serial clock: the higher bit of the pair on spi_di0 and the lower bit on spi_di1, pairs in order (7,6), (5,4), (3,2), (1,0). Each completed byte is driven on nand_dq_out with nand_dq_oe high.
- R4: Each completed multi-write byte produces exactly one nand_we_n low pulse of at least WE_CYCLES (default 2) system clocks. The data is stable on the bus one clock before the pulse starts.
- R5: Opcode 0x0A (multi-read) is followed by one idle byte and then read slots. Each slot returns one NAND byte on spi_do, MSB first. spi_do changes only after falling serial clock edges, so each bit is valid at the following rising edge.
- R6: Opcode 0x0B (fast read) behaves like multi-read, but with four idle bytes before the first read slot.
- R7: A read transaction with N slots produces exactly N+1 nand_re_n low pulses, the last being a prefetch for a slot the host may not clock. Slot k returns the byte present on nand_dq_in during the k-th pulse. No read pulse occurs in any other phase.
- R8: Raising spi_cs_n aborts a partly received byte and returns the decoder to waiting for an opcode. An aborted configuration byte leaves the configuration register unchanged.
- R9: Any opcode other than 0x08 to 0x0B makes every further byte of that transaction have no effect: no write pulse, no read pulse, no configuration change.
- R10: During multi-write byte slots spi_do carries the synchronised nand_rb level. During the opcode byte and idle bytes spi_do is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_di0 | input | 1 | Serial data in, lane 0 (single-lane data and upper bit of a pair) |
| spi_di1 | input | 1 | Serial data in, lane 1 (lower bit of a pair) |
| spi_do | output | 1 | Serial data out |
| nand_dq_in | input | 8 | NAND data bus, read direction |
| nand_dq_out | output | 8 | NAND data bus, write direction |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_ce_n | output | 1 | NAND chip enable, active low |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ale | output | 1 | NAND address latch enable |
| nand_we_n | output | 1 | NAND write enable, active low |
| nand_re_n | output | 1 | NAND read enable, active low |
| nand_rb | input | 1 | NAND ready/busy |
| fan_on | output | 1 | Fan control output |
| led_n | output | 4 | LED outputs, active low |

## Verification
Random configuration bytes with mixed bit patterns show whether each register bit reaches its own pin. Random multi-write bursts of one to five bytes use data whose pair bits differ, which exposes swapped lanes or swapped pair order. The bursts also expose lost or doubled write pulses. Multi-read and fast-read bursts of random length against a changing NAND data model distinguish the one and four idle-byte framings, off-by-one slot alignment and a wrong count of read pulses. Directed cases abort a transaction in the middle of a byte and send an unknown opcode followed by legal-looking bytes, to show that neither reaches the NAND pins or the configuration.

// File: rtl/snb_pkg.sv
package snb_pkg;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_CFG,
        PH_WDATA,
        PH_IDLE,
        PH_READ,
        PH_IGNORE
    } phase_e;

    localparam logic [7:0] OP_MWRITE = 8'h08;
    localparam logic [7:0] OP_WCFG   = 8'h09;
    localparam logic [7:0] OP_MREAD  = 8'h0A;
    localparam logic [7:0] OP_FREAD  = 8'h0B;
    localparam logic [7:0] CFG_RESET = 8'h8F;

endpackage

// File: rtl/snb_sync.sv
module snb_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/snb_strobe.sv
module snb_strobe #(
    parameter int CYCLES = 2,
    parameter int SETUP  = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic strobe_n,
    output logic last
);

    localparam int TOTAL = CYCLES + SETUP;
    localparam int CW    = $clog2(TOTAL + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)               cnt_d = CW'(TOTAL);
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign strobe_n = !((cnt_q != '0) && (cnt_q <= CW'(CYCLES)));
    assign last     = (cnt_q == CW'(1));

endmodule

// File: rtl/spi_nand_bridge.sv
module spi_nand_bridge
    import snb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WE_CYCLES   = 2,
    parameter int RE_CYCLES   = 2,
    parameter int MULTI_IDLE  = 1,
    parameter int FAST_IDLE   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_cs_n,
    input  logic       spi_sck,
    input  logic       spi_di0,
    input  logic       spi_di1,
    output logic       spi_do,
    input  logic [7:0] nand_dq_in,
    output logic [7:0] nand_dq_out,
    output logic       nand_dq_oe,
    output logic       nand_ce_n,
    output logic       nand_cle,
    output logic       nand_ale,
    output logic       nand_we_n,
    output logic       nand_re_n,
    input  logic       nand_rb,
    output logic       fan_on,
    output logic [3:0] led_n
);

    localparam int IDLE_W   = $clog2(FAST_IDLE + 1);
    localparam int SYNC_W   = 5;
    localparam logic [2:0] LAST_SINGLE = 3'd7;
    localparam logic [2:0] LAST_DUAL   = 3'd3;

    typedef struct packed {
        phase_e            phase;
        logic [2:0]        bitc;
        logic [IDLE_W-1:0] idle;
        logic [7:0]        sh;
        logic [7:0]        tx;
        logic              sdo;
        logic [7:0]        cfg;
        logic [7:0]        dout;
        logic              sck_prev;
    } state_t;

    localparam state_t STATE_RESET = '{
        phase:    PH_CMD,
        bitc:     '0,
        idle:     '0,
        sh:       '0,
        tx:       '0,
        sdo:      1'b0,
        cfg:      CFG_RESET,
        dout:     '0,
        sck_prev: 1'b0
    };

    state_t st_d, st_q;

    logic [SYNC_W-1:0] sync_v;
    logic cs_s, sck_s, di0_s, di1_s, rb_s;
    logic we_go, re_go, re_last;
    logic rise, fall, dual, byte_done;
    logic [7:0] nxt_sh;

    snb_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b00001)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({nand_rb, spi_di1, spi_di0, spi_sck, spi_cs_n}),
        .sync_o  (sync_v)
    );

    assign {rb_s, di1_s, di0_s, sck_s, cs_s} = sync_v;

    snb_strobe #(.CYCLES(WE_CYCLES), .SETUP(1)) i_we (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (we_go),
        .strobe_n (nand_we_n),
        .last     ()
    );

    snb_strobe #(.CYCLES(RE_CYCLES), .SETUP(0)) i_re (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (re_go),
        .strobe_n (nand_re_n),
        .last     (re_last)
    );

    always_comb begin
        st_d      = st_q;
        we_go     = 1'b0;
        re_go     = 1'b0;
        rise      = sck_s & ~st_q.sck_prev;
        fall      = ~sck_s & st_q.sck_prev;
        dual      = (st_q.phase == PH_WDATA);
        nxt_sh    = dual ? {st_q.sh[5:0], di0_s, di1_s} : {st_q.sh[6:0], di0_s};
        byte_done = dual ? (st_q.bitc == LAST_DUAL) : (st_q.bitc == LAST_SINGLE);
        st_d.sck_prev = sck_s;

        if (re_last) st_d.tx = nand_dq_in;

        if (cs_s) begin
            st_d.phase = PH_CMD;
            st_d.bitc  = '0;
            st_d.sdo   = 1'b0;
        end else begin
            if (rise) begin
                st_d.sh   = nxt_sh;
                st_d.bitc = byte_done ? '0 : st_q.bitc + 1'b1;
                if (byte_done) begin
                    unique case (st_q.phase)
                        PH_CMD: begin
                            unique case (nxt_sh)
                                OP_MWRITE: st_d.phase = PH_WDATA;
                                OP_WCFG:   st_d.phase = PH_CFG;
                                OP_MREAD: begin
                                    st_d.phase = PH_IDLE;
                                    st_d.idle  = IDLE_W'(MULTI_IDLE - 1);
                                end
                                OP_FREAD: begin
                                    st_d.phase = PH_IDLE;
                                    st_d.idle  = IDLE_W'(FAST_IDLE - 1);
                                end
                                default:   st_d.phase = PH_IGNORE;
                            endcase
                        end
                        PH_CFG:   st_d.cfg = nxt_sh;
                        PH_WDATA: begin
                            st_d.dout = nxt_sh;
                            we_go     = 1'b1;
                        end
                        PH_IDLE: begin
                            if (st_q.idle == '0) begin
                                st_d.phase = PH_READ;
                                re_go      = 1'b1;
                            end else begin
                                st_d.idle = st_q.idle - 1'b1;
                            end
                        end
                        PH_READ:   re_go = 1'b1;
                        default:   ;
                    endcase
                end
            end
            if (fall) begin
                if (st_q.phase == PH_READ) begin
                    st_d.sdo = st_q.tx[7];
                    st_d.tx  = {st_q.tx[6:0], 1'b0};
                end else if (st_q.phase == PH_WDATA) begin
                    st_d.sdo = rb_s;
                end else begin
                    st_d.sdo = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= STATE_RESET;
        else        st_q <= st_d;
    end

    assign spi_do      = st_q.sdo;
    assign nand_dq_out = st_q.dout;
    assign nand_dq_oe  = (st_q.phase == PH_WDATA) | ~nand_we_n;
    assign nand_ce_n   = st_q.cfg[7];
    assign nand_cle    = st_q.cfg[6];
    assign nand_ale    = st_q.cfg[5];
    assign fan_on      = st_q.cfg[4];
    assign led_n       = st_q.cfg[3:0];

endmodule

// File: rtl/snb_checker.sv
module snb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       nand_dq_oe,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       fan_on,
    input logic [3:0] led_n
);

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n)); // R7

    AST_BUS_DRIVEN_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_dq_oe); // R3

    AST_WE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n) |=> !nand_we_n); // R4

    AST_RE_IN_TRANSACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_re_n) |-> !spi_cs_n); // R7

    AST_CFG_ONLY_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({nand_ce_n, nand_cle, nand_ale, fan_on, led_n}) |-> !$past(spi_cs_n)); // R2

endmodule

bind spi_nand_bridge snb_checker i_snb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (spi_cs_n),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .fan_on     (fan_on),
    .led_n      (led_n)
);

// File: tb/test_spi_nand_bridge.sv
`timescale 1ns/1ps
module test_spi_nand_bridge;

    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1, spi_sck = 1'b0, spi_di0 = 1'b0, spi_di1 = 1'b0;
    logic       spi_do;
    logic [7:0] nand_dq_in, nand_dq_out;
    logic       nand_dq_oe, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic       nand_rb = 1'b1;
    logic       fan_on;
    logic [3:0] led_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0] mem [64];
    logic [5:0] rptr = '0;
    int         rn = 0, wn = 0, short_we = 0, oe_bad = 0, wlen = 0;
    logic [7:0] wlog [256];
    logic       prev_we = 1'b1, prev_re = 1'b1;

    always #4 clk = ~clk;

    spi_nand_bridge i_spi_nand_bridge (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_di0(spi_di0), .spi_di1(spi_di1), .spi_do(spi_do),
        .nand_dq_in(nand_dq_in), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_rb(nand_rb),
        .fan_on(fan_on), .led_n(led_n)
    );

    assign nand_dq_in = mem[rptr];

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        prev_we <= nand_we_n;
        prev_re <= nand_re_n;
        if (prev_we && !nand_we_n) begin
            wlog[wn[7:0]] <= nand_dq_out;
            wn   <= wn + 1;
            wlen <= 1;
            if (!nand_dq_oe) oe_bad <= oe_bad + 1;
        end else if (!nand_we_n) begin
            wlen <= wlen + 1;
        end
        if (!prev_we && nand_we_n && wlen < 2) short_we <= short_we + 1;
        if (!prev_re && nand_re_n) begin
            rptr <= rptr + 1'b1;
            rn   <= rn + 1;
        end
    end

    always @(posedge clk) begin
        if (cyc > 190000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 190000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pins();
        return {nand_ce_n, nand_cle, nand_ale, fan_on, led_n};
    endfunction

    task automatic sbits(input logic [7:0] b, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            spi_di0 = b[i];
            repeat (H) @(negedge clk);
            rx[i] = spi_do;
            spi_sck = 1'b1;
            repeat (H) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic sbyte(input logic [7:0] b, output logic [7:0] rx);
        sbits(b, 8, rx);
    endtask

    task automatic dbyte(input logic [7:0] b, output logic [3:0] rx);
        for (int i = 0; i < 4; i++) begin
            spi_di0 = b[7-2*i];
            spi_di1 = b[6-2*i];
            repeat (H) @(negedge clk);
            rx[3-i] = spi_do;
            spi_sck = 1'b1;
            repeat (H) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic cs_lo();
        spi_cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (2*H) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4*H) @(negedge clk);
    endtask

    task automatic do_cfg(input logic [7:0] v);
        logic [7:0] rx;
        cs_lo();
        sbyte(8'h09, rx);
        sbyte(v, rx);
        cs_hi();
    endtask

    task automatic do_write(input int n);
        logic [7:0] data [8];
        logic [7:0] rx;
        logic [3:0] r4;
        int base;
        nand_rb = 1'($urandom);
        repeat (4) @(negedge clk);
        base = wn;
        cs_lo();
        sbyte(8'h08, rx);
        chk(rx == 8'h00, "R10 opcode slot returns 0", rx, 0);
        for (int k = 0; k < n; k++) begin
            data[k] = 8'($urandom);
            dbyte(data[k], r4);
            chk(r4 == {4{nand_rb}}, "R10 write slot returns ready/busy", r4, {4{nand_rb}});
        end
        cs_hi();
        chk(wn - base == n, "R4 one write pulse per byte", wn - base, n);
        for (int k = 0; k < n; k++)
            chk(wlog[8'(base + k)] == data[k], "R3 dual-lane byte on NAND bus", wlog[8'(base + k)], data[k]);
    endtask

    task automatic do_read(input logic [7:0] op, input int idle, input int n);
        logic [7:0] rx;
        logic [5:0] base;
        int rbase;
        base  = rptr;
        rbase = rn;
        cs_lo();
        sbyte(op, rx);
        for (int k = 0; k < idle; k++) begin
            sbyte(8'h00, rx);
            chk(rx == 8'h00, "R10 idle slot returns 0", rx, 0);
        end
        chk(rn == rbase + 1, "R7 single prefetch before first slot", rn - rbase, 1);
        for (int k = 0; k < n; k++) begin
            sbyte(8'h00, rx);
            chk(rx == mem[base + 6'(k)], (op == 8'h0B) ? "R6 fast read slot" : "R5 multi read slot",
                rx, mem[base + 6'(k)]);
        end
        cs_hi();
        chk(rn - rbase == n + 1, "R7 read pulse count", rn - rbase, n + 1);
    endtask

    initial begin
        logic [7:0] rx;
        logic [7:0] cfg_exp;
        int wb, rb0;
        void'($urandom(32'd20240607));
        for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk(pins() == 8'h8F, "R1 reset configuration", pins(), 8'h8F);
        chk(nand_we_n && nand_re_n && !nand_dq_oe, "R1 strobes idle after reset",
            {nand_we_n, nand_re_n, nand_dq_oe}, 3'b110);

        // R2 configuration writes: directed then random
        do_cfg(8'h55);
        chk(pins() == 8'h55, "R2 config pins", pins(), 8'h55);
        do_cfg(8'hA0);
        chk(pins() == 8'hA0, "R2 config pins", pins(), 8'hA0);
        for (int t = 0; t < 5; t++) begin
            cfg_exp = 8'($urandom);
            do_cfg(cfg_exp);
            chk(pins() == cfg_exp, "R2 config pins random", pins(), cfg_exp);
        end
        cfg_exp = pins();

        // R3 R4 R10 multi-write
        do_write(1);
        for (int t = 0; t < 4; t++) do_write(1 + int'($urandom_range(4)));
        chk(short_we == 0, "R4 write pulse width at least two clocks", short_we, 0);
        chk(oe_bad == 0, "R3 bus enabled during write pulse", oe_bad, 0);

        // R5 R6 R7 reads
        do_read(8'h0A, 1, 1);
        do_read(8'h0A, 1, 2 + int'($urandom_range(4)));
        do_read(8'h0B, 4, 1);
        do_read(8'h0B, 4, 2 + int'($urandom_range(4)));

        // R8 abort in a config byte
        cfg_exp = pins();
        wb = wn; rb0 = rn;
        cs_lo();
        sbyte(8'h09, rx);
        sbits(8'h00, 4, rx);
        cs_hi();
        chk(pins() == cfg_exp, "R8 aborted config byte ignored", pins(), cfg_exp);
        // R8 abort in an opcode byte, then a clean transaction
        cs_lo();
        sbits(8'h08, 5, rx);
        cs_hi();
        do_cfg(8'h3C);
        chk(pins() == 8'h3C, "R8 decoder resynchronised after abort", pins(), 8'h3C);

        // R9 unknown opcode
        wb = wn; rb0 = rn;
        cs_lo();
        sbyte(8'h5A, rx);
        sbyte(8'h09, rx);
        sbyte(8'h00, rx);
        sbyte(8'h08, rx);
        sbyte(8'hFF, rx);
        cs_hi();
        chk(pins() == 8'h3C, "R9 unknown opcode leaves config", pins(), 8'h3C);
        chk(wn == wb, "R9 unknown opcode makes no write", wn - wb, 0);
        chk(rn == rb0, "R9 unknown opcode makes no read", rn - rb0, 0);

        // R7 no read pulse outside read phases
        chk(rn == rb0, "R7 no read pulse in other phases", rn - rb0, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule